// File: doc/BRIEF.md
# Power-Mode Sequencer for an 8-bit Core

The sequencer sits beside the instruction decoder of a small 8-bit processor and sets how much of the chip keeps a clock. When the decoder presents one of two halt opcodes, the block moves into one of two sleep depths. In deep stop, the main oscillator and every clock are switched off. In light idle, only the CPU clock and most peripheral clocks are gated, and a small group of always-on peripherals keeps running. The block drives the clock-enable outputs for the oscillator, the CPU and each peripheral. It also holds the two-bit clock-divider select field.

Wake-up depends on the sleep depth. Deep stop ends only through reset or through one of four filtered external interrupt lines. An interrupt wake from stop must first wait for the oscillator to settle. That wait is a down-counter loaded with a value captured when stop was entered. Idle ends on any enabled interrupt, internal or external, and goes straight back to running because the oscillator never stopped.

Reset always runs a fixed settling wait. It then clears the divider field to the slowest setting and tells the CPU to fetch from the boot vector. An interrupt wake keeps the divider field as it was and issues a one-cycle service pulse instead.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: A halt is requested only when `op_valid_i` is high. Opcode 8'h7F requests deep stop and opcode 8'h6F requests idle. Any other opcode leaves the clock enables and the divider field unchanged.
- R2: In deep stop, `osc_en_o`, `cpu_clk_en_o` and every bit of `per_clk_en_o` are low.
- R3: Deep stop is left by an interrupt only when a bit of `ext_irq_i` is high and the matching bit of `ext_en_i` is high. Internal interrupts and disabled external lines keep the oscillator off.
- R4: After an external wake from stop, the block spends exactly L+1 cycles with `osc_en_o` high and `cpu_clk_en_o` low. L is the value of `stab_sel_i` in the cycle the stop opcode was accepted. Later changes to `stab_sel_i` have no effect on that wait.
- R5: An interrupt wake, from either stop or idle, re-enables the CPU clock. In that same cycle it raises `svc_irq_o` for exactly one cycle, with `boot_o` low and `clksel_o` unchanged.
- R6: In idle, `cpu_clk_en_o` is low, `osc_en_o` is high and `per_clk_en_o` equals the always-on mask AON_MASK. The default mask is 8'b0000_0111: bit 0 is the display timer, bit 1 the PWM unit and bit 2 the capture unit.
- R7: Idle is left in the very next cycle by any interrupt, internal or external, whose enable is set, with no settling wait. While every pending interrupt is masked, idle persists.
- R8: Reset sets `clksel_o` to 2'b00 and holds the CPU clock off for RST_STAB+1 cycles after release, where RST_STAB defaults to 8. It then raises `boot_o` for one cycle, with `fetch_addr_o` = 16'h0100 and `svc_irq_o` low.
- R9: A halt opcode arriving while any enabled interrupt is pending is cancelled, and the block stays running with all clocks on.
- R10: `clksel_wr_i` loads `clksel_wdata_i` into `clksel_o` only while running. A write attempted during idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on control clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Opcode strobe from decode |
| opcode_i | input | 8 | Decoded opcode |
| ext_irq_i | input | 4 | Filtered external interrupt pending lines |
| ext_en_i | input | 4 | Enables for the external lines |
| int_irq_i | input | N_INT | Internal interrupt pending lines |
| int_en_i | input | N_INT | Enables for the internal lines |
| stab_sel_i | input | CNT_W | Settling count used for the next stop wake |
| clksel_wr_i | input | 1 | Write strobe for the divider field |
| clksel_wdata_i | input | 2 | New divider field value |
| osc_en_o | output | 1 | Main oscillator enable |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| per_clk_en_o | output | N_PER | Per-peripheral clock gate enables |
| clksel_o | output | 2 | Divider select field, 2'b00 is divide-by-16 |
| svc_irq_o | output | 1 | Pulse: resume by servicing the interrupt |
| boot_o | output | 1 | Pulse: fetch from the boot vector |
| fetch_addr_o | output | 16 | Boot vector address, valid with boot_o |

## Verification
The hardest case to reach is the one that shows the settling count is captured at stop entry and not read live. The bench programs one count, issues the stop opcode, and then changes `stab_sel_i` while the oscillator is off. Only after that does it raise an enabled external line. It then counts the cycles in which the oscillator is on but the CPU is not, and that count must follow the old value. A second hard case is an internal interrupt arriving during stop, which must be shown to change nothing. The bench holds it for several cycles and then confirms that the oscillator is still off.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
  typedef enum logic [2:0] {
    PM_RUN  = 3'd0,
    PM_IDLE = 3'd1,
    PM_STOP = 3'd2,
    PM_STAB = 3'd3,
    PM_WAKE = 3'd4
  } pm_state_e;

  localparam logic [7:0]  OP_STOP  = 8'h7F;
  localparam logic [7:0]  OP_IDLE  = 8'h6F;
  localparam logic [15:0] BOOT_VEC = 16'h0100;
endpackage

// File: rtl/pmc_wake_src.sv
module pmc_wake_src #(
  parameter int N_EXT = 4,
  parameter int N_INT = 4
) (
  input  logic [N_EXT-1:0] ext_irq_i,
  input  logic [N_EXT-1:0] ext_en_i,
  input  logic [N_INT-1:0] int_irq_i,
  input  logic [N_INT-1:0] int_en_i,
  output logic             stop_wake_o,
  output logic             any_wake_o
);
  logic ext_hit, int_hit;
  assign ext_hit     = |(ext_irq_i & ext_en_i);
  assign int_hit     = |(int_irq_i & int_en_i);
  assign stop_wake_o = ext_hit;           // only filtered external lines may end stop
  assign any_wake_o  = ext_hit | int_hit;
endmodule

// File: rtl/pmc_stab_cnt.sv
module pmc_stab_cnt #(
  parameter int          CNT_W   = 16,
  parameter logic [15:0] RST_VAL = 16'd8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= CNT_W'(RST_VAL);
    else if (load_i)                cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/pmc_clk_gates.sv
module pmc_clk_gates
  import pwr_mode_pkg::*;
#(
  parameter int               N_PER    = 8,
  parameter logic [N_PER-1:0] AON_MASK = N_PER'(3'b111)
) (
  input  pm_state_e        state_i,
  output logic             osc_en_o,
  output logic             cpu_clk_en_o,
  output logic [N_PER-1:0] per_clk_en_o
);
  logic run_like, idle_st;
  assign run_like     = (state_i == PM_RUN) || (state_i == PM_WAKE);
  assign idle_st      = (state_i == PM_IDLE);
  assign osc_en_o     = (state_i != PM_STOP);
  assign cpu_clk_en_o = run_like;

  for (genvar p = 0; p < N_PER; p++) begin : g_per
    if (AON_MASK[p]) begin : g_aon
      assign per_clk_en_o[p] = run_like | idle_st;
    end else begin : g_gated
      assign per_clk_en_o[p] = run_like;
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int               N_INT    = 4,
  parameter int               N_PER    = 8,
  parameter int               CNT_W    = 16,
  parameter logic [15:0]      RST_STAB = 16'd8,
  parameter logic [N_PER-1:0] AON_MASK = N_PER'(3'b111)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             op_valid_i,
  input  logic [7:0]       opcode_i,
  input  logic [3:0]       ext_irq_i,
  input  logic [3:0]       ext_en_i,
  input  logic [N_INT-1:0] int_irq_i,
  input  logic [N_INT-1:0] int_en_i,
  input  logic [CNT_W-1:0] stab_sel_i,
  input  logic             clksel_wr_i,
  input  logic [1:0]       clksel_wdata_i,
  output logic             osc_en_o,
  output logic             cpu_clk_en_o,
  output logic [N_PER-1:0] per_clk_en_o,
  output logic [1:0]       clksel_o,
  output logic             svc_irq_o,
  output logic             boot_o,
  output logic [15:0]      fetch_addr_o
);
  pm_state_e        state_q, state_d;
  logic [CNT_W-1:0] stab_q;
  logic [1:0]       clksel_q;
  logic             from_rst_q;
  logic             stop_wake, any_wake, stab_done, cnt_load;
  logic             req_stop, req_idle;

  pmc_wake_src #(.N_EXT(4), .N_INT(N_INT)) u_wake (
    .ext_irq_i  (ext_irq_i),
    .ext_en_i   (ext_en_i),
    .int_irq_i  (int_irq_i),
    .int_en_i   (int_en_i),
    .stop_wake_o(stop_wake),
    .any_wake_o (any_wake)
  );

  assign cnt_load = (state_q == PM_STOP) && stop_wake;

  pmc_stab_cnt #(.CNT_W(CNT_W), .RST_VAL(RST_STAB)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (cnt_load),
    .load_val_i(stab_q),
    .run_i     (state_q == PM_STAB),
    .done_o    (stab_done)
  );

  pmc_clk_gates #(.N_PER(N_PER), .AON_MASK(AON_MASK)) u_gates (
    .state_i     (state_q),
    .osc_en_o    (osc_en_o),
    .cpu_clk_en_o(cpu_clk_en_o),
    .per_clk_en_o(per_clk_en_o)
  );

  // a pending enabled interrupt cancels a halt in the same cycle
  assign req_stop = op_valid_i && (opcode_i == OP_STOP) && !any_wake;
  assign req_idle = op_valid_i && (opcode_i == OP_IDLE) && !any_wake;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PM_RUN:  if (req_stop) state_d = PM_STOP;
               else if (req_idle) state_d = PM_IDLE;
      PM_IDLE: if (any_wake) state_d = PM_WAKE;
      PM_STOP: if (stop_wake) state_d = PM_STAB;
      PM_STAB: if (stab_done) state_d = PM_WAKE;
      PM_WAKE: state_d = PM_RUN;
      default: state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= PM_STAB;
      from_rst_q <= 1'b1;
      clksel_q   <= 2'b00;
      stab_q     <= CNT_W'(RST_STAB);
    end else begin
      state_q <= state_d;
      if (state_q == PM_WAKE) from_rst_q <= 1'b0;
      if (state_q == PM_RUN && req_stop) stab_q <= stab_sel_i;
      if (state_q == PM_RUN && clksel_wr_i) clksel_q <= clksel_wdata_i;
    end
  end

  assign clksel_o     = clksel_q;
  assign svc_irq_o    = (state_q == PM_WAKE) && !from_rst_q;
  assign boot_o       = (state_q == PM_WAKE) && from_rst_q;
  assign fetch_addr_o = boot_o ? BOOT_VEC : 16'h0000;
endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
module pwr_mode_ctrl_chk
  import pwr_mode_pkg::*;
#(
  parameter int N_INT = 4,
  parameter int N_PER = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             op_valid_i,
  input logic [7:0]       opcode_i,
  input logic [3:0]       ext_irq_i,
  input logic [3:0]       ext_en_i,
  input logic [N_INT-1:0] int_irq_i,
  input logic [N_INT-1:0] int_en_i,
  input logic             osc_en_o,
  input logic             cpu_clk_en_o,
  input logic [N_PER-1:0] per_clk_en_o,
  input logic [1:0]       clksel_o,
  input logic             svc_irq_o,
  input logic             boot_o,
  input logic [15:0]      fetch_addr_o
);
  logic pend;
  assign pend = |(ext_irq_i & ext_en_i) | |(int_irq_i & int_en_i);

  a_r9_halt_cancel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_clk_en_o && !svc_irq_o && !boot_o && op_valid_i && pend &&
     (opcode_i == OP_STOP || opcode_i == OP_IDLE)) |=> cpu_clk_en_o);

  a_r2_stop_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> (!cpu_clk_en_o && per_clk_en_o == '0));

  a_r3_stop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_en_o && !(|(ext_irq_i & ext_en_i))) |=> !osc_en_o);

  a_r4_osc_before_cpu: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(osc_en_o) |-> !cpu_clk_en_o);

  a_r5_svc_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_irq_o |=> !svc_irq_o);

  a_r5_svc_keeps_clksel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_irq_o |-> ($stable(clksel_o) && !boot_o && cpu_clk_en_o));

  a_r8_boot_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_o |-> (fetch_addr_o == BOOT_VEC && clksel_o == 2'b00 && !svc_irq_o));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.N_INT(N_INT), .N_PER(N_PER)) u_chk (.*);

// File: tb/pwr_mode_ctrl_bench.sv
module pwr_mode_ctrl_bench;
  localparam int N_INT = 4;
  localparam int N_PER = 8;
  localparam int CNT_W = 16;
  localparam logic [N_PER-1:0] AON = 8'b0000_0111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [7:0] opcode = '0;
  logic [3:0] ext_irq = '0, ext_en = '0;
  logic [N_INT-1:0] int_irq = '0, int_en = '0;
  logic [CNT_W-1:0] stab_sel = '0;
  logic clksel_wr = 1'b0;
  logic [1:0] clksel_wdata = '0;
  logic osc_en, cpu_en, svc, boot;
  logic [N_PER-1:0] per_en;
  logic [1:0] clksel;
  logic [15:0] faddr;
  int n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  pwr_mode_ctrl u_pwr_mode_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .opcode_i(opcode),
    .ext_irq_i(ext_irq), .ext_en_i(ext_en), .int_irq_i(int_irq), .int_en_i(int_en),
    .stab_sel_i(stab_sel), .clksel_wr_i(clksel_wr), .clksel_wdata_i(clksel_wdata),
    .osc_en_o(osc_en), .cpu_clk_en_o(cpu_en), .per_clk_en_o(per_en),
    .clksel_o(clksel), .svc_irq_o(svc), .boot_o(boot), .fetch_addr_o(faddr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // counts cycles with oscillator on and CPU gated, until CPU clock returns
  task automatic wait_cpu(output int n_stab);
    n_stab = 0;
    for (int i = 0; i < 2000; i++) begin
      #1;
      if (cpu_en) break;
      if (osc_en) n_stab++;
      @(negedge clk);
    end
  endtask

  task automatic issue_op(input logic [7:0] op);
    @(negedge clk);
    op_valid = 1'b1; opcode = op;
    @(negedge clk);
    op_valid = 1'b0; opcode = '0;
    #1;
  endtask

  task automatic write_sel(input logic [1:0] v);
    @(negedge clk);
    clksel_wr = 1'b1; clksel_wdata = v;
    @(negedge clk);
    clksel_wr = 1'b0;
    #1;
  endtask

  task automatic do_reset();
    int n;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8 clksel in reset", 32'(clksel), 32'd0);
    check("R8 cpu gated in reset", 32'(cpu_en), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    wait_cpu(n);
    check("R8 reset settle cycles", 32'(n), 32'd9);
    check("R8 boot pulse", 32'(boot), 32'd1);
    check("R8 boot vector", 32'(faddr), 32'h0100);
    check("R8 no svc on boot", 32'(svc), 32'd0);
    @(negedge clk); #1;
    check("R8 boot single cycle", 32'(boot), 32'd0);
  endtask

  task automatic t_other_opcode();
    issue_op(8'h7E);
    check("R1 other opcode keeps cpu", 32'(cpu_en), 32'd1);
    check("R1 other opcode keeps per", 32'(per_en), 32'hFF);
    @(negedge clk);
    opcode = 8'h7F; // opcode without strobe
    @(negedge clk); opcode = '0; #1;
    check("R1 no strobe no stop", 32'(osc_en), 32'd1);
  endtask

  task automatic t_cancel();
    int_en = 4'b0010; int_irq = 4'b0010;
    issue_op(8'h7F);
    check("R9 stop cancelled", 32'(cpu_en), 32'd1);
    issue_op(8'h6F);
    check("R9 idle cancelled", 32'(per_en), 32'hFF);
    int_irq = '0; int_en = '0;
  endtask

  task automatic t_stop_ext_wake();
    int n;
    write_sel(2'b11);
    ext_en = 4'b1000; int_en = 4'b1111;
    stab_sel = 16'd5;
    issue_op(8'h7F);
    check("R2 stop osc off", 32'(osc_en), 32'd0);
    check("R2 stop cpu off", 32'(cpu_en), 32'd0);
    check("R2 stop per off", 32'(per_en), 32'd0);
    stab_sel = 16'd40; // must not change this wake
    @(negedge clk);
    int_irq = 4'b0100; ext_irq = 4'b0111; // internal + disabled external lines
    repeat (5) @(negedge clk);
    #1;
    check("R3 internal/disabled ignored", 32'(osc_en), 32'd0);
    @(negedge clk);
    int_irq = '0; ext_irq = 4'b1000;
    wait_cpu(n);
    check("R4 settle cycles from captured value", 32'(n), 32'd6);
    check("R5 svc pulse", 32'(svc), 32'd1);
    check("R5 no boot", 32'(boot), 32'd0);
    check("R5 clksel kept", 32'(clksel), 32'd3);
    @(negedge clk);
    ext_irq = '0; ext_en = '0; int_en = '0;
    #1;
    check("R5 svc single cycle", 32'(svc), 32'd0);
  endtask

  task automatic t_stop_zero();
    int n;
    ext_en = 4'b0001; stab_sel = 16'd0;
    issue_op(8'h7F);
    @(negedge clk);
    ext_irq = 4'b0001;
    wait_cpu(n);
    check("R4 zero count settle", 32'(n), 32'd1);
    @(negedge clk);
    ext_irq = '0; ext_en = '0;
  endtask

  task automatic t_idle();
    write_sel(2'b10);
    int_irq = 4'b0001; // pending but masked
    issue_op(8'h6F);
    check("R6 idle cpu off", 32'(cpu_en), 32'd0);
    check("R6 idle osc on", 32'(osc_en), 32'd1);
    check("R6 idle aon mask", 32'(per_en), 32'(AON));
    // write during idle is refused
    clksel_wr = 1'b1; clksel_wdata = 2'b01;
    @(negedge clk); clksel_wr = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R7 masked stays idle", 32'(cpu_en), 32'd0);
    check("R10 idle write blocked", 32'(clksel), 32'd2);
    int_en = 4'b0001;
    @(negedge clk); #1;
    check("R7 idle wakes next cycle", 32'(cpu_en), 32'd1);
    check("R5 idle svc", 32'(svc), 32'd1);
    check("R5 idle clksel kept", 32'(clksel), 32'd2);
    int_irq = '0; int_en = '0;
  endtask

  task automatic t_idle_ext_then_reset();
    issue_op(8'h6F);
    ext_en = 4'b0100; ext_irq = 4'b0100;
    @(negedge clk); #1;
    check("R7 external wakes idle", 32'(svc), 32'd1);
    ext_irq = '0; ext_en = '0;
    issue_op(8'h6F);
    check("R6 back in idle", 32'(cpu_en), 32'd0);
    do_reset();
    check("R8 clksel cleared after idle reset", 32'(clksel), 32'd0);
    write_sel(2'b01);
    check("R10 run write", 32'(clksel), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    do_reset();
    check("R1 running after boot", 32'(per_en), 32'hFF);
    t_other_opcode();
    t_cancel();
    t_stop_ext_wake();
    t_stop_zero();
    t_idle();
    t_idle_ext_then_reset();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule